// File: doc/BRIEF.md
# Scoreboard Function-Unit Dependency Matrix

This block keeps track of register hazards among a small pool of function units. When an instruction is issued to a unit, the unit provides a destination register number and two source register numbers. The matrix compares them once against the other busy units and stores the result as one bit for each unit pair. There are no per-cycle comparisons of register numbers after issue. Each unit then receives two grants that are computed separately: permission to read its operands and permission to write its result. A unit can therefore start executing while it is still held back from completing.

Speculation uses extra branch rows. While a branch row is active, every unit issued under it carries a shadow bit for that branch, and the shadow withholds only the write grant. When the branch is confirmed correct, the shadow is lifted. When it is mispredicted, every unit under the shadow is cancelled without writing, and its dependency bits disappear from the other rows. The function units drive the read-done, result-ready and write-done handshakes. The issue stage watches the stall output.

Top module: `sb_dep_matrix`

## Requirements
- R1: While reset is asserted and right after it is released, no unit is busy, no read or write grant is given, no branch row is active, no unit is cancelled and the stall output is low.
- R2: A valid issue stalls, and changes no state, when the target unit is busy or when a busy unit that is not freeing this cycle already has the same destination register. Two busy units never share a destination.
- R3: A unit that issues with a source equal to a busy unit's destination gets no read grant until that producer completes its write. The grant rises in the cycle after the producer's write-done.
- R4: The read grant is high when a unit is busy, has not yet read and has no pending read-after-write bit. A read-done pulse is accepted only while the grant is high, and accepting it ends the grant.
- R5: A unit that issues with a destination equal to a source of a busy unit that has not yet read gets no write grant until that unit has read.
- R6: The write grant is high when a unit is busy, has read, has its result-ready input high, carries no shadow and has no pending write-after-read bit. A write-done pulse is ignored while the grant is low. An accepted write-done frees the unit in the next cycle.
- R7: A unit under an active branch shadow receives its read grant normally but no write grant.
- R8: A branch-correct pulse on index b deactivates branch row b and removes shadow b from every unit. An unshadowed ready unit gets its write grant in the next cycle.
- R9: A branch-mispredict pulse on index b raises the cancel output in the same cycle for every busy unit shadowed by b. Those units are idle in the next cycle, branch row b is inactive, and their dependency bits no longer block other units.
- R10: A unit that completes its write in a cycle neither stalls nor becomes a dependency of an issue in that same cycle.
- R11: A branch-issue pulse with index b activates branch row b from the next cycle. A unit issued while no branch row is active is never held back by a shadow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| issue_vld | input | 1 | Issue request |
| issue_fu | input | FU_W | Target unit index |
| issue_dst | input | REG_W | Destination register number |
| issue_src1 | input | REG_W | First source register number |
| issue_src2 | input | REG_W | Second source register number |
| issue_stall | output | 1 | Issue request refused this cycle |
| rd_done | input | NUM_FU | Per-unit operand read completed |
| res_rdy | input | NUM_FU | Per-unit result available (level) |
| wr_done | input | NUM_FU | Per-unit result write completed |
| go_rd | output | NUM_FU | Per-unit read grant |
| go_wr | output | NUM_FU | Per-unit write grant |
| fu_busy | output | NUM_FU | Per-unit occupied flag |
| fu_cancel | output | NUM_FU | Per-unit cancellation this cycle |
| br_issue_vld | input | 1 | Open a branch row |
| br_issue_idx | input | BR_W | Branch row index to open |
| br_ok | input | NUM_BR | Per-branch resolved correct |
| br_bad | input | NUM_BR | Per-branch resolved mispredicted |
| br_active | output | NUM_BR | Per-branch row active |

## Verification
The hardest situations to reach are the ones where two events fall in the same cycle. In one, a producer's write-done arrives together with an issue that names its destination. In the other, a unit's write is held only by a write-after-read bit that a different unit's read must clear. The stimulus table reaches both by stepping a chain of three units. The second unit reads the first unit's result. The third unit overwrites a register the second has not yet read. Read-done and result-ready are released one cycle at a time so that each grant is observed as it opens. Directed sequences then open branch rows, issue dependent units beneath them, and resolve the branches both ways.

// File: rtl/sb_pkg.sv
package sb_pkg;
  localparam int unsigned SB_FUS   = 4;
  localparam int unsigned SB_BRS   = 2;
  localparam int unsigned SB_REG_W = 5;

  function automatic int unsigned idx_w(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/sb_branch_rows.sv
module sb_branch_rows #(
  parameter int unsigned NUM_BR = 2,
  parameter int unsigned BR_W   = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              br_issue_vld,
  input  logic [BR_W-1:0]   br_issue_idx,
  input  logic [NUM_BR-1:0] br_ok,
  input  logic [NUM_BR-1:0] br_bad,
  output logic [NUM_BR-1:0] br_busy,
  output logic [NUM_BR-1:0] br_rel
);
  logic [NUM_BR-1:0] busy_q, busy_d, open_v;

  always_comb begin
    open_v = '0;
    if (br_issue_vld) open_v[br_issue_idx] = 1'b1;
    br_rel = (br_ok | br_bad) & busy_q;
    busy_d = (busy_q | open_v) & ~(br_ok | br_bad);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) busy_q <= '0;
    else        busy_q <= busy_d;
  end

  assign br_busy = busy_q;

  for (genvar b = 0; b < NUM_BR; b++) begin : g_chk
    assert_branch_resolve_R8 : assert property (@(posedge clk) disable iff (!rst_n)
      (br_ok[b] || br_bad[b]) |=> !br_busy[b]);
    assert_branch_open_R11 : assert property (@(posedge clk) disable iff (!rst_n)
      (br_issue_vld && br_issue_idx == b && !br_ok[b] && !br_bad[b]) |=> br_busy[b]);
  end
endmodule

// File: rtl/sb_issue_ctl.sv
module sb_issue_ctl #(
  parameter int unsigned NUM_FU = 4,
  parameter int unsigned NUM_BR = 2,
  parameter int unsigned REG_W  = 5,
  parameter int unsigned FU_W   = 2
) (
  input  logic                           issue_vld,
  input  logic [FU_W-1:0]                issue_fu,
  input  logic [REG_W-1:0]               issue_dst,
  input  logic [REG_W-1:0]               issue_src1,
  input  logic [REG_W-1:0]               issue_src2,
  input  logic [NUM_FU-1:0]              busy,
  input  logic [NUM_FU-1:0]              rd_pend,
  input  logic [NUM_FU-1:0][REG_W-1:0]   dst_a,
  input  logic [NUM_FU-1:0][REG_W-1:0]   s1_a,
  input  logic [NUM_FU-1:0][REG_W-1:0]   s2_a,
  input  logic [NUM_FU-1:0]              rd_fire,
  input  logic [NUM_FU-1:0]              free,
  input  logic [NUM_BR-1:0]              br_busy,
  input  logic [NUM_BR-1:0]              br_rel,
  output logic                           stall,
  output logic [NUM_FU-1:0]              take,
  output logic [NUM_FU-1:0]              raw_new,
  output logic [NUM_FU-1:0]              war_new,
  output logic [NUM_BR-1:0]              shd_new
);
  logic [NUM_FU-1:0] alive, dst_hit;

  always_comb begin
    for (int j = 0; j < NUM_FU; j++) begin
      alive[j]   = busy[j] & ~free[j];
      dst_hit[j] = alive[j] & (dst_a[j] == issue_dst);
      raw_new[j] = alive[j] & ((dst_a[j] == issue_src1) | (dst_a[j] == issue_src2));
      war_new[j] = alive[j] & rd_pend[j] & ~rd_fire[j] &
                   ((s1_a[j] == issue_dst) | (s2_a[j] == issue_dst));
    end
    stall = issue_vld & (busy[issue_fu] | (|dst_hit));
    take  = '0;
    if (issue_vld && !stall) take[issue_fu] = 1'b1;
    shd_new = br_busy & ~br_rel;
  end
endmodule

// File: rtl/sb_fu_row.sv
module sb_fu_row #(
  parameter int unsigned NUM_FU = 4,
  parameter int unsigned NUM_BR = 2,
  parameter int unsigned REG_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take_i,
  input  logic [REG_W-1:0]  dst_i,
  input  logic [REG_W-1:0]  s1_i,
  input  logic [REG_W-1:0]  s2_i,
  input  logic [NUM_FU-1:0] raw_new_i,
  input  logic [NUM_FU-1:0] war_new_i,
  input  logic [NUM_BR-1:0] shd_new_i,
  input  logic              rd_done_i,
  input  logic              res_rdy_i,
  input  logic              wr_done_i,
  input  logic [NUM_FU-1:0] peer_rd_fire_i,
  input  logic [NUM_FU-1:0] peer_free_i,
  input  logic [NUM_BR-1:0] br_rel_i,
  input  logic [NUM_BR-1:0] br_bad_i,
  output logic              busy_o,
  output logic              rd_pend_o,
  output logic [REG_W-1:0]  dst_o,
  output logic [REG_W-1:0]  s1_o,
  output logic [REG_W-1:0]  s2_o,
  output logic              go_rd_o,
  output logic              go_wr_o,
  output logic              rd_fire_o,
  output logic              wr_fire_o,
  output logic              kill_o
);
  logic              busy_q, busy_d, rdp_q, rdp_d;
  logic [NUM_FU-1:0] raw_q, raw_d, war_q, war_d;
  logic [NUM_BR-1:0] shd_q, shd_d;
  logic [REG_W-1:0]  dst_q, s1_q, s2_q;

  assign kill_o    = busy_q & (|(shd_q & br_bad_i));
  assign go_rd_o   = busy_q & rdp_q & ~(|raw_q);
  assign rd_fire_o = go_rd_o & rd_done_i & ~kill_o;
  assign go_wr_o   = busy_q & ~rdp_q & res_rdy_i & ~(|shd_q) & ~(|war_q);
  assign wr_fire_o = go_wr_o & wr_done_i;

  always_comb begin
    busy_d = busy_q;
    rdp_d  = rdp_q & ~rd_fire_o;
    raw_d  = raw_q & ~peer_free_i;
    war_d  = war_q & ~(peer_rd_fire_i | peer_free_i);
    shd_d  = shd_q & ~br_rel_i;
    if (take_i) begin
      busy_d = 1'b1;
      rdp_d  = 1'b1;
      raw_d  = raw_new_i;
      war_d  = war_new_i;
      shd_d  = shd_new_i;
    end else if (wr_fire_o || kill_o) begin
      busy_d = 1'b0;
      rdp_d  = 1'b0;
      raw_d  = '0;
      war_d  = '0;
      shd_d  = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      rdp_q  <= 1'b0;
      raw_q  <= '0;
      war_q  <= '0;
      shd_q  <= '0;
    end else begin
      busy_q <= busy_d;
      rdp_q  <= rdp_d;
      raw_q  <= raw_d;
      war_q  <= war_d;
      shd_q  <= shd_d;
    end
  end

  always_ff @(posedge clk) begin
    if (take_i) begin
      dst_q <= dst_i;
      s1_q  <= s1_i;
      s2_q  <= s2_i;
    end
  end

  assign busy_o    = busy_q;
  assign rd_pend_o = rdp_q;
  assign dst_o     = dst_q;
  assign s1_o      = s1_q;
  assign s2_o      = s2_q;

  assert_take_idle_R2 : assert property (@(posedge clk) disable iff (!rst_n)
    take_i |-> !busy_q);
  assert_read_once_R4 : assert property (@(posedge clk) disable iff (!rst_n)
    rd_fire_o |=> !go_rd_o);
  assert_write_frees_R6 : assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire_o |=> !busy_o);
  assert_cancel_frees_R9 : assert property (@(posedge clk) disable iff (!rst_n)
    kill_o |=> !busy_o);
endmodule

// File: rtl/sb_dep_matrix.sv
module sb_dep_matrix
  import sb_pkg::*;
#(
  parameter int unsigned NUM_FU = SB_FUS,
  parameter int unsigned NUM_BR = SB_BRS,
  parameter int unsigned REG_W  = SB_REG_W,
  localparam int unsigned FU_W  = idx_w(NUM_FU),
  localparam int unsigned BR_W  = idx_w(NUM_BR)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue_vld,
  input  logic [FU_W-1:0]   issue_fu,
  input  logic [REG_W-1:0]  issue_dst,
  input  logic [REG_W-1:0]  issue_src1,
  input  logic [REG_W-1:0]  issue_src2,
  output logic              issue_stall,
  input  logic [NUM_FU-1:0] rd_done,
  input  logic [NUM_FU-1:0] res_rdy,
  input  logic [NUM_FU-1:0] wr_done,
  output logic [NUM_FU-1:0] go_rd,
  output logic [NUM_FU-1:0] go_wr,
  output logic [NUM_FU-1:0] fu_busy,
  output logic [NUM_FU-1:0] fu_cancel,
  input  logic              br_issue_vld,
  input  logic [BR_W-1:0]   br_issue_idx,
  input  logic [NUM_BR-1:0] br_ok,
  input  logic [NUM_BR-1:0] br_bad,
  output logic [NUM_BR-1:0] br_active
);
  logic [NUM_FU-1:0]            busy, rdp, rd_fire, wr_fire, kill, free, take;
  logic [NUM_FU-1:0]            raw_new, war_new;
  logic [NUM_FU-1:0][REG_W-1:0] dst_a, s1_a, s2_a;
  logic [NUM_BR-1:0]            br_busy, br_rel, shd_new;

  assign free = wr_fire | kill;

  sb_branch_rows #(.NUM_BR(NUM_BR), .BR_W(BR_W)) u_br (
    .clk(clk), .rst_n(rst_n), .br_issue_vld(br_issue_vld),
    .br_issue_idx(br_issue_idx), .br_ok(br_ok), .br_bad(br_bad),
    .br_busy(br_busy), .br_rel(br_rel));

  sb_issue_ctl #(.NUM_FU(NUM_FU), .NUM_BR(NUM_BR), .REG_W(REG_W), .FU_W(FU_W)) u_iss (
    .issue_vld(issue_vld), .issue_fu(issue_fu), .issue_dst(issue_dst),
    .issue_src1(issue_src1), .issue_src2(issue_src2), .busy(busy), .rd_pend(rdp),
    .dst_a(dst_a), .s1_a(s1_a), .s2_a(s2_a), .rd_fire(rd_fire), .free(free),
    .br_busy(br_busy), .br_rel(br_rel), .stall(issue_stall), .take(take),
    .raw_new(raw_new), .war_new(war_new), .shd_new(shd_new));

  for (genvar i = 0; i < NUM_FU; i++) begin : g_row
    sb_fu_row #(.NUM_FU(NUM_FU), .NUM_BR(NUM_BR), .REG_W(REG_W)) u_row (
      .clk(clk), .rst_n(rst_n), .take_i(take[i]),
      .dst_i(issue_dst), .s1_i(issue_src1), .s2_i(issue_src2),
      .raw_new_i(raw_new), .war_new_i(war_new), .shd_new_i(shd_new),
      .rd_done_i(rd_done[i]), .res_rdy_i(res_rdy[i]), .wr_done_i(wr_done[i]),
      .peer_rd_fire_i(rd_fire), .peer_free_i(free),
      .br_rel_i(br_rel), .br_bad_i(br_bad),
      .busy_o(busy[i]), .rd_pend_o(rdp[i]), .dst_o(dst_a[i]),
      .s1_o(s1_a[i]), .s2_o(s2_a[i]), .go_rd_o(go_rd[i]), .go_wr_o(go_wr[i]),
      .rd_fire_o(rd_fire[i]), .wr_fire_o(wr_fire[i]), .kill_o(kill[i]));
  end

  assign fu_busy   = busy;
  assign fu_cancel = kill;
  assign br_active = br_busy;

  for (genvar i = 0; i < NUM_FU; i++) begin : g_pair_i
    for (genvar j = i + 1; j < NUM_FU; j++) begin : g_pair_j
      assert_unique_dst_R2 : assert property (@(posedge clk) disable iff (!rst_n)
        !(busy[i] && busy[j] && dst_a[i] == dst_a[j]));
    end
  end
endmodule

// File: tb/test_sb_dep_matrix.sv
module test_sb_dep_matrix;
  localparam int NF = 4;
  localparam int NB = 2;
  localparam int RW = 5;

  logic clk, rst_n;
  logic issue_vld;
  logic [1:0] issue_fu;
  logic [RW-1:0] issue_dst, issue_src1, issue_src2;
  logic issue_stall;
  logic [NF-1:0] rd_done, res_rdy, wr_done, go_rd, go_wr, fu_busy, fu_cancel;
  logic br_issue_vld;
  logic [0:0] br_issue_idx;
  logic [NB-1:0] br_ok, br_bad, br_active;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  sb_dep_matrix i_sb_dep_matrix (
    .clk(clk), .rst_n(rst_n), .issue_vld(issue_vld), .issue_fu(issue_fu),
    .issue_dst(issue_dst), .issue_src1(issue_src1), .issue_src2(issue_src2),
    .issue_stall(issue_stall), .rd_done(rd_done), .res_rdy(res_rdy),
    .wr_done(wr_done), .go_rd(go_rd), .go_wr(go_wr), .fu_busy(fu_busy),
    .fu_cancel(fu_cancel), .br_issue_vld(br_issue_vld),
    .br_issue_idx(br_issue_idx), .br_ok(br_ok), .br_bad(br_bad),
    .br_active(br_active));

  initial clk = 1'b0;
  always #5 clk = ~clk;

  typedef struct packed {
    logic       iv;
    logic [1:0] fu;
    logic [4:0] d, a, b;
    logic [3:0] rd, rr, wd;
    logic       st;
    logic [3:0] bz, gr, gw;
  } vec_t;

  localparam vec_t TBL [12] = '{
    '{1'b1, 2'd0, 5'd3, 5'd1, 5'd2, 4'h0, 4'h0, 4'h0, 1'b0, 4'h1, 4'h1, 4'h0},
    '{1'b1, 2'd1, 5'd4, 5'd3, 5'd5, 4'h0, 4'h0, 4'h0, 1'b0, 4'h3, 4'h1, 4'h0},
    '{1'b1, 2'd2, 5'd3, 5'd0, 5'd0, 4'h0, 4'h0, 4'h0, 1'b1, 4'h3, 4'h1, 4'h0},
    '{1'b0, 2'd0, 5'd0, 5'd0, 5'd0, 4'h1, 4'h0, 4'h0, 1'b0, 4'h3, 4'h0, 4'h0},
    '{1'b0, 2'd0, 5'd0, 5'd0, 5'd0, 4'h0, 4'h1, 4'h0, 1'b0, 4'h3, 4'h0, 4'h1},
    '{1'b0, 2'd0, 5'd0, 5'd0, 5'd0, 4'h0, 4'h1, 4'h1, 1'b0, 4'h2, 4'h2, 4'h0},
    '{1'b1, 2'd2, 5'd5, 5'd6, 5'd7, 4'h0, 4'h0, 4'h0, 1'b0, 4'h6, 4'h6, 4'h0},
    '{1'b0, 2'd0, 5'd0, 5'd0, 5'd0, 4'h4, 4'h4, 4'h0, 1'b0, 4'h6, 4'h2, 4'h0},
    '{1'b0, 2'd0, 5'd0, 5'd0, 5'd0, 4'h2, 4'h4, 4'h0, 1'b0, 4'h6, 4'h0, 4'h4},
    '{1'b0, 2'd0, 5'd0, 5'd0, 5'd0, 4'h0, 4'h4, 4'h6, 1'b0, 4'h2, 4'h0, 4'h0},
    '{1'b1, 2'd3, 5'd4, 5'd0, 5'd0, 4'h0, 4'h2, 4'h2, 1'b0, 4'h8, 4'h8, 4'h0},
    '{1'b1, 2'd0, 5'd8, 5'd4, 5'd4, 4'h0, 4'h0, 4'h0, 1'b0, 4'h9, 4'h8, 4'h0}
  };

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic clear_in();
    issue_vld = 0; issue_fu = '0; issue_dst = '0; issue_src1 = '0; issue_src2 = '0;
    rd_done = '0; res_rdy = '0; wr_done = '0;
    br_issue_vld = 0; br_issue_idx = '0; br_ok = '0; br_bad = '0;
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic idle();
    @(negedge clk);
    clear_in();
  endtask

  task automatic do_reset();
    @(negedge clk);
    clear_in();
    rst_n = 0;
    #2;
    chk("R1", "busy in reset", int'(fu_busy), 0);
    chk("R1", "grants in reset", int'({go_rd, go_wr}), 0);
    chk("R1", "branch rows in reset", int'(br_active), 0);
    repeat (2) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic issue(input int fu, input int d, input int a, input int b);
    issue_vld = 1; issue_fu = 2'(fu); issue_dst = 5'(d);
    issue_src1 = 5'(a); issue_src2 = 5'(b);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    clear_in();
    rst_n = 0;
    do_reset();
    #2;
    chk("R1", "busy after reset", int'(fu_busy), 0);
    chk("R1", "grants after reset", int'({go_rd, go_wr, fu_cancel}), 0);
    chk("R1", "stall after reset", int'(issue_stall), 0);

    // Table: R2 stall, R3 RAW, R4 read grant, R5 WAR, R6 write grant, R10 same-cycle free
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      clear_in();
      issue_vld = TBL[k].iv; issue_fu = TBL[k].fu; issue_dst = TBL[k].d;
      issue_src1 = TBL[k].a; issue_src2 = TBL[k].b;
      rd_done = TBL[k].rd; res_rdy = TBL[k].rr; wr_done = TBL[k].wd;
      #1;
      chk((k == 10) ? "R10" : "R2", $sformatf("stall step %0d", k), int'(issue_stall), int'(TBL[k].st));
      tick();
      chk("R2", $sformatf("busy step %0d", k), int'(fu_busy), int'(TBL[k].bz));
      chk((k == 5) ? "R3" : "R4", $sformatf("go_rd step %0d", k), int'(go_rd), int'(TBL[k].gr));
      chk((k == 7) ? "R5" : "R6", $sformatf("go_wr step %0d", k), int'(go_wr), int'(TBL[k].gw));
    end

    // R7 / R8 / R11: shadowed unit reads but does not write until branch is confirmed
    do_reset();
    idle(); br_issue_vld = 1; br_issue_idx = 1'b0;
    tick(); chk("R11", "branch row 0 active", int'(br_active), 1);
    idle(); issue(0, 1, 2, 3);
    tick(); chk("R7", "shadowed unit read grant", int'(go_rd), 1);
    idle(); rd_done = 4'h1; res_rdy = 4'h1;
    tick(); chk("R7", "shadowed unit write grant", int'(go_wr), 0);
    idle(); res_rdy = 4'h1; wr_done = 4'h1;
    tick(); chk("R6", "write-done ignored without grant", int'(fu_busy), 1);
    idle(); res_rdy = 4'h1; br_ok = 2'b01;
    tick(); chk("R8", "write grant after confirm", int'(go_wr), 1);
    chk("R8", "branch row released", int'(br_active), 0);
    idle(); res_rdy = 4'h1; wr_done = 4'h1;
    tick(); chk("R6", "unit freed after write", int'(fu_busy), 0);
    idle(); issue(2, 9, 0, 0);
    tick();
    idle(); rd_done = 4'h4; res_rdy = 4'h4;
    tick(); chk("R11", "unshadowed unit write grant", int'(go_wr), 4);

    // R9: mispredict cancels shadowed producer and consumer
    do_reset();
    idle(); br_issue_vld = 1; br_issue_idx = 1'b1;
    tick();
    idle(); issue(1, 6, 0, 0);
    tick();
    idle(); issue(2, 7, 6, 6);
    tick(); chk("R3", "consumer blocked by producer", int'(go_rd), 2);
    idle(); br_bad = 2'b10;
    #1; chk("R9", "cancel pulse", int'(fu_cancel), 6);
    tick(); chk("R9", "cancelled units idle", int'(fu_busy), 0);
    chk("R9", "branch row cleared", int'(br_active), 0);
    idle(); issue(3, 7, 6, 6);
    #1; chk("R9", "no stall after cancel", int'(issue_stall), 0);
    tick(); chk("R9", "no stale dependency", int'(go_rd), 8);

    // R4: read-done without grant is ignored
    do_reset();
    idle(); issue(0, 9, 1, 1);
    tick();
    idle(); issue(1, 10, 9, 9);
    tick();
    idle(); rd_done = 4'h2;
    tick(); chk("R4", "blocked read grant", int'(go_rd), 1);
    idle(); rd_done = 4'h1; res_rdy = 4'h1;
    tick();
    idle(); res_rdy = 4'h1; wr_done = 4'h1;
    tick(); chk("R4", "early read-done ignored", int'(go_rd), 2);
    chk("R3", "producer freed", int'(fu_busy), 2);

    finished = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule